// File: doc/BRIEF.md
# OFDM Subcarrier Point Arranger

This block sits between a constellation mapper and a 64-point inverse FFT. It collects complex points from an I/Q stream and treats each run of 48 accepted points as the payload of one OFDM symbol. It then writes out a full 64-bin frequency-domain frame with one bin per cycle, in natural bin order from 0 to 63. Each frame holds the payload points, four pilot tones and zero-filled bins. The pilot sign for the frame comes from a polarity input, so an upstream sequence generator can scramble the pilots from one symbol to the next.

The input uses a valid/ready handshake. While a frame is being written out the block deasserts ready, so the upstream stage stalls. The output has no backpressure: once a frame starts, its 64 bins leave on 64 consecutive cycles. A start-of-symbol flag marks bin 0 of each frame, and the current bin index comes out beside the data.

Top module: `ofdm_bin_arranger`

## Requirements
- R1: After reset, `out_valid` and `out_sos` are 0 and `in_ready` is 1.
- R2: A point is accepted on a clock edge where `in_valid` and `in_ready` are both 1. The edge that accepts the 48th point of a symbol drops `in_ready` and starts the frame, so bin 0 is valid on the next cycle.
- R3: Subcarrier k is output at bin k for k ≥ 0 and at bin 64+k for k < 0. The 48 payload points of a symbol, in arrival order, fill subcarriers −26..−22, −20..−8, −6..−1, 1..6, 8..20 and 22..26, in that ascending order.
- R4: Bin 0 (DC) and bins 27..37 (subcarriers outside −26..26) output I = Q = 0.
- R5: With polarity 0, the pilots at subcarriers −21, −7 and +7 (bins 43, 57, 7) output I = +PILOT_AMP. The pilot at +21 (bin 21) outputs I = −PILOT_AMP. Every pilot has Q = 0.
- R6: `pilot_neg` is sampled on the edge that accepts the 48th point. When it is 1, the frame that follows carries all four pilot values negated.
- R7: A frame is 64 consecutive cycles with `out_valid` = 1, and `out_bin` steps 0, 1, …, 63.
- R8: `out_sos` is 1 exactly on the cycle that carries bin 0.
- R9: `in_ready` is 0 on every cycle of a frame. Input offered during a frame is not taken into the next symbol.
- R10: On the cycle after bin 63, `out_valid` is 0 and `in_ready` is 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input point offered |
| in_ready | output | 1 | Block can accept a point |
| in_i | input | IQ_W | Input in-phase value, two's complement |
| in_q | input | IQ_W | Input quadrature value, two's complement |
| pilot_neg | input | 1 | Pilot polarity for the symbol, sampled with the last point |
| out_valid | output | 1 | Output bin valid |
| out_sos | output | 1 | First bin of a frame |
| out_bin | output | 6 | Bin index of the current output |
| out_i | output | IQ_W | Output in-phase value |
| out_q | output | IQ_W | Output quadrature value |

## Verification
A fault in the write pointer or the bin map shows up as a payload point in the wrong bin, or a pilot or zero overwritten, within the first frame after the fault. The bench compares every bin of every frame, so such a fault is reported within at most 64 output cycles. A wrong handshake or phase state shows up as `in_ready` high during a frame, a gap or repeat in `out_bin`, or a start flag away from bin 0. Most of these are caught on the cycle where they happen. A stale polarity register shows up as flipped pilot signs in the next frame.

// File: rtl/arr_pkg.sv
// Package: shared constants and the bin classification type for the
// subcarrier point arranger. Assumes a 64-bin frame with 48 payload points.
package arr_pkg;
    localparam int N_BINS = 64;
    localparam int N_DATA = 48;
    localparam int BIN_W  = $clog2(N_BINS);
    localparam int IDX_W  = $clog2(N_DATA);

    typedef enum logic [1:0] {
        BK_ZERO      = 2'd0,
        BK_DATA      = 2'd1,
        BK_PILOT_POS = 2'd2,
        BK_PILOT_NEG = 2'd3
    } bin_kind_t;
endpackage

// File: rtl/arr_bin_map.sv
// Module: arr_bin_map
// Purely combinational. It classifies a frame bin as zero, payload or pilot.
// For a payload bin it also gives the index of the payload point that belongs
// there. Assumes the fixed 64-bin layout with negative subcarriers in the
// upper half.
module arr_bin_map
    import arr_pkg::*;
(
    input  logic [BIN_W-1:0] bin,
    output bin_kind_t        kind,
    output logic [IDX_W-1:0] idx
);
    // Decode the bin into its kind and payload index.
    always_comb begin
        kind = BK_ZERO;
        idx  = '0;
        if (bin >= 6'd1 && bin <= 6'd6) begin
            kind = BK_DATA; idx = bin + 6'd23;
        end else if (bin >= 6'd8 && bin <= 6'd20) begin
            kind = BK_DATA; idx = bin + 6'd22;
        end else if (bin >= 6'd22 && bin <= 6'd26) begin
            kind = BK_DATA; idx = bin + 6'd21;
        end else if (bin >= 6'd38 && bin <= 6'd42) begin
            kind = BK_DATA; idx = bin - 6'd38;
        end else if (bin >= 6'd44 && bin <= 6'd56) begin
            kind = BK_DATA; idx = bin - 6'd39;
        end else if (bin >= 6'd58) begin
            kind = BK_DATA; idx = bin - 6'd40;
        end else if (bin == 6'd7 || bin == 6'd43 || bin == 6'd57) begin
            kind = BK_PILOT_POS;
        end else if (bin == 6'd21) begin
            kind = BK_PILOT_NEG;
        end
    end
endmodule

// File: rtl/arr_sym_buf.sv
// Module: arr_sym_buf
// Holds the payload points of one symbol. It has one write port and one
// combinational read port. The storage has no reset, because every entry is
// written before it is read.
module arr_sym_buf
    import arr_pkg::*;
#(
    parameter int IQ_W = 12
) (
    input  logic            clk,
    input  logic            wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [IQ_W-1:0] wr_i,
    input  logic [IQ_W-1:0] wr_q,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [IQ_W-1:0] rd_i,
    output logic [IQ_W-1:0] rd_q
);
    logic [IQ_W-1:0] mem_i [N_DATA];
    logic [IQ_W-1:0] mem_q [N_DATA];

    // Store an accepted point at its arrival index.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_i[wr_idx] <= wr_i;
            mem_q[wr_idx] <= wr_q;
        end
    end

    // Read the point selected by the current bin.
    always_comb begin
        rd_i = mem_i[rd_idx];
        rd_q = mem_q[rd_idx];
    end
endmodule

// File: rtl/arr_seq.sv
// Module: arr_seq
// Two-phase sequencer. In the fill phase it counts accepted points. In the
// emit phase it steps the bin counter through 64 cycles. The pilot polarity
// is latched with the last point of a symbol. Assumes no output backpressure.
module arr_seq
    import arr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             pilot_neg,
    output logic             in_ready,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic             emitting,
    output logic [BIN_W-1:0] bin_cnt,
    output logic             pol_q
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_DATA - 1);
    localparam logic [BIN_W-1:0] LAST_BIN = BIN_W'(N_BINS - 1);

    // Handshake: accept points only during the fill phase.
    always_comb begin
        in_ready = !emitting;
        wr_en    = in_valid && !emitting;
    end

    // Move between the phases and advance the fill and bin counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            emitting <= 1'b0;
            wr_idx   <= '0;
            bin_cnt  <= '0;
            pol_q    <= 1'b0;
        end else if (!emitting) begin
            if (in_valid) begin
                if (wr_idx == LAST_IDX) begin
                    wr_idx   <= '0;
                    emitting <= 1'b1;
                    bin_cnt  <= '0;
                    pol_q    <= pilot_neg;
                end else begin
                    wr_idx <= wr_idx + 1'b1;
                end
            end
        end else begin
            if (bin_cnt == LAST_BIN) begin
                emitting <= 1'b0;
            end
            bin_cnt <= bin_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ofdm_bin_arranger.sv
// Module: ofdm_bin_arranger (top)
// Buffers 48 constellation points, then writes out a 64-bin frame in natural
// bin order. The frame carries the buffered points, four pilots and zero bins.
// Assumes PILOT_AMP is representable in IQ_W signed bits.
module ofdm_bin_arranger
    import arr_pkg::*;
#(
    parameter int IQ_W      = 12,
    parameter int PILOT_AMP = 1024
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [IQ_W-1:0]     in_i,
    input  logic [IQ_W-1:0]     in_q,
    input  logic                pilot_neg,
    output logic                out_valid,
    output logic                out_sos,
    output logic [BIN_W-1:0]    out_bin,
    output logic [IQ_W-1:0]     out_i,
    output logic [IQ_W-1:0]     out_q
);
    localparam logic [IQ_W-1:0] AMP_POS = IQ_W'(PILOT_AMP);
    localparam logic [IQ_W-1:0] AMP_NEG = IQ_W'(-PILOT_AMP);

    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic             emitting;
    logic [BIN_W-1:0] bin_cnt;
    logic             pol_q;
    bin_kind_t        kind;
    logic [IDX_W-1:0] rd_idx;
    logic [IQ_W-1:0]  rd_i;
    logic [IQ_W-1:0]  rd_q;
    logic             pilot_flip;

    arr_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .pilot_neg(pilot_neg),
        .in_ready (in_ready),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .emitting (emitting),
        .bin_cnt  (bin_cnt),
        .pol_q    (pol_q)
    );

    arr_sym_buf #(.IQ_W(IQ_W)) u_buf (
        .clk   (clk),
        .wr_en (wr_en),
        .wr_idx(wr_idx),
        .wr_i  (in_i),
        .wr_q  (in_q),
        .rd_idx(rd_idx),
        .rd_i  (rd_i),
        .rd_q  (rd_q)
    );

    arr_bin_map u_map (
        .bin (bin_cnt),
        .kind(kind),
        .idx (rd_idx)
    );

    // Select the payload point, the signed pilot or zero for the current bin.
    always_comb begin
        out_valid  = emitting;
        out_sos    = emitting && (bin_cnt == '0);
        out_bin    = bin_cnt;
        pilot_flip = (kind == BK_PILOT_NEG) ^ pol_q;
        out_i      = '0;
        out_q      = '0;
        if (emitting) begin
            unique case (kind)
                BK_DATA: begin
                    out_i = rd_i;
                    out_q = rd_q;
                end
                BK_PILOT_POS, BK_PILOT_NEG: out_i = pilot_flip ? AMP_NEG : AMP_POS;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/arr_checker.sv
// Module: arr_checker
// Protocol and layout properties of the arranger. It is attached to every
// instance of the top module by the bind below.
module arr_checker
    import arr_pkg::*;
#(
    parameter int IQ_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_sos,
    input logic [BIN_W-1:0] out_bin,
    input logic [IQ_W-1:0]  out_i,
    input logic [IQ_W-1:0]  out_q
);
    AST_NO_READY_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready); // R9
    AST_SOS_ON_BIN0: assert property (@(posedge clk) disable iff (!rst_n)
        out_sos |-> (out_valid && out_bin == '0)); // R8
    AST_FRAME_OPENS_SOS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_bin == '0) |-> out_sos); // R8
    AST_BIN_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_bin != 6'd63) |=> (out_valid && out_bin == BIN_W'($past(out_bin) + 1'b1))); // R7
    AST_DC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_bin == '0) |-> (out_i == '0 && out_q == '0)); // R4
    AST_PILOT_Q_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (out_bin == 6'd7 || out_bin == 6'd21 || out_bin == 6'd43 || out_bin == 6'd57))
        |-> (out_q == '0)); // R5
    AST_READY_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_bin == 6'd63) |=> (in_ready && !out_valid)); // R10
endmodule

bind ofdm_bin_arranger arr_checker #(.IQ_W(IQ_W)) u_chk (.*);

// File: tb/ofdm_bin_arranger_bench.sv
`timescale 1ns/1ps
module ofdm_bin_arranger_bench;
    localparam int IQ_W = 12;
    localparam int AMP  = 1024;
    localparam int NSYM = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [IQ_W-1:0] in_i = '0;
    logic [IQ_W-1:0] in_q = '0;
    logic pilot_neg = 1'b0;
    logic out_valid, out_sos;
    logic [5:0] out_bin;
    logic [IQ_W-1:0] out_i, out_q;

    int checks = 0;
    int errors = 0;
    int rec_i [48];
    int rec_q [48];
    int fr_i [48];
    int fr_q [48];
    int rcnt = 0;
    bit exp_pol = 0;
    bit chk_start = 0;
    bit chk_after = 0;
    int ob = 0;
    int frames = 0;
    bit done = 0;

    ofdm_bin_arranger #(.IQ_W(IQ_W), .PILOT_AMP(AMP)) u_ofdm_bin_arranger (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_i(in_i), .in_q(in_q), .pilot_neg(pilot_neg), .out_valid(out_valid),
        .out_sos(out_sos), .out_bin(out_bin), .out_i(out_i), .out_q(out_q)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Expected I/Q of a bin, computed from the subcarrier layout.
    function automatic void exp_bin(input int b, output int ei, output int eq, output string tag);
        int k;
        int idx;
        k = (b < 32) ? b : b - 64;
        ei = 0; eq = 0; tag = "R4";
        if (k == 0 || k > 26 || k < -26) begin
            tag = "R4";
        end else if (k == -21 || k == -7 || k == 7 || k == 21) begin
            ei = (k == 21) ? -AMP : AMP;
            if (exp_pol) ei = -ei;
            tag = exp_pol ? "R6" : "R5";
        end else begin
            idx = 0;
            for (int s = -26; s < k; s++)
                if (s != 0 && s != 7 && s != -7 && s != 21 && s != -21) idx++;
            ei = fr_i[idx]; eq = fr_q[idx];
            tag = "R3";
        end
    endfunction

    // Monitor and recorder, sampling away from the active edge.
    always @(negedge clk) begin
        int ei, eq;
        string tag;
        if (rst_n) begin
            if (chk_start) begin
                chk(out_valid && out_sos && !in_ready, "R2", {out_valid, out_sos, in_ready}, 3'b110);
                chk_start = 0;
            end
            if (out_valid) begin
                chk(out_bin == ob[5:0], "R7", out_bin, ob);
                chk(out_sos == (ob == 0), "R8", out_sos, ob == 0);
                chk(!in_ready, "R9", in_ready, 0);
                exp_bin(ob, ei, eq, tag);
                chk($signed(out_i) == ei, tag, $signed(out_i), ei);
                chk($signed(out_q) == eq, tag, $signed(out_q), eq);
                if (ob == 63) begin ob = 0; chk_after = 1; frames++; end
                else ob++;
            end else if (chk_after) begin
                chk(in_ready && !out_valid, "R10", {in_ready, out_valid}, 2'b10);
                chk_after = 0;
            end
            if (in_valid && in_ready) begin
                rec_i[rcnt] = $signed(in_i);
                rec_q[rcnt] = $signed(in_q);
                if (rcnt == 47) begin
                    fr_i = rec_i; fr_q = rec_q;
                    exp_pol = pilot_neg;
                    rcnt = 0; chk_start = 1;
                end else rcnt++;
            end
        end
    end

    // Offer the 48 points of one symbol; mode 0 ramp, 1 extremes, 2 random.
    task automatic send_symbol(input int mode, input bit pol, input bit gaps);
        int sent = 0;
        while (sent < 48) begin
            @(posedge clk); #1;
            if (gaps && ($urandom % 4 == 0)) begin
                in_valid = 1'b0;
            end else begin
                in_valid = 1'b1;
                pilot_neg = pol;
                case (mode)
                    0: begin in_i = IQ_W'(sent + 1); in_q = IQ_W'(-(sent + 1)); end
                    1: begin in_i = sent[0] ? 12'h7FF : 12'h800; in_q = sent[0] ? 12'h800 : 12'h7FF; end
                    default: begin in_i = IQ_W'($urandom); in_q = IQ_W'($urandom); end
                endcase
            end
            @(negedge clk);
            if (in_valid && in_ready) sent++;
        end
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid && !out_sos && in_ready, "R1", {out_valid, out_sos, in_ready}, 3'b001);
        send_symbol(0, 1'b0, 1'b0);
        send_symbol(0, 1'b1, 1'b0);
        send_symbol(1, 1'b0, 1'b1);
        for (int n = 0; n < NSYM; n++) begin
            int m = ($urandom % 2 == 0) ? 1 : 0;
            send_symbol(2, m[0], 1'b1);
        end
        wait (frames == NSYM + 3);
        repeat (4) @(negedge clk);
        chk(!out_valid && in_ready, "R10", {out_valid, in_ready}, 2'b01);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog R7 actual=%0d expected=%0d", frames, NSYM + 3);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule